// File: doc/BRIEF.md
# Scanline Bus-Request and Retrace Timer

This block paces CPU access to a memory shared with a video fetch engine. A line-start pulse marks the start of each scanline and carries its line number. In the legacy mode, a line that lies inside the active display area raises a bus request to the CPU at its start. The request drops again after a fixed share of the line period, 368 of every 456 line clocks, which frees the RAM for video fetches during that time. In the alternate mode the block raises no bus request. Instead it emits a single-clock vertical-retrace interrupt on the line that follows the last active line.

A CRT mode register is loaded through a plain write strobe with an 8-bit value. Bit 1 is inverted and selects the active line count: 200 lines when the bit is clear, 192 when it is set. Bit 0 gives the frame height used in the alternate mode. Bits 2 and 3 are kept inverted as two general mode flags. A display-kill input blocks every bus request. All pins are plain control or status signals, so there is no handshake and no back-pressure. The line-start input must be a one-clock pulse.

Top module: `scanline_bus_timer`

## Requirements
- R1: After reset, bus_req and retrace_irq are 0, frame_lines is 204, mode_flags is 2'b00, and the active line count is 192. The reset register value is 8'h0E.
- R2: The active line count is 200 when bit 1 of the last written mode byte is 0, and 192 when that bit is 1.
- R3: In legacy mode (alt_mode=0) with disp_kill=0, a line_start whose line_num is below the active count raises bus_req on the clock that follows it.
- R4: Once raised, bus_req stays high for exactly HOLD = LINE_CLKS*368/456 clocks and then falls. A line_start whose line_num is at or above the active count leaves bus_req low.
- R5: While disp_kill is 1, no bus request starts, and a request already in progress falls on the next clock.
- R6: While alt_mode is 1, no bus request starts, and a request already in progress falls on the next clock.
- R7: With alt_mode=1, a line_start whose line_num equals the active count raises retrace_irq for exactly one clock, on the clock that follows. No other line raises it, and it never rises with alt_mode=0.
- R8: frame_lines is 200 when bit 0 of the mode byte is 1, and 204 when that bit is 0.
- R9: mode_flags[1] is the inverse of mode byte bit 3, and mode_flags[0] is the inverse of bit 2.
- R10: A mode write takes effect for line starts after its clock edge. A line_start in the same cycle as the write uses the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-clock pulse at the start of a scanline |
| line_num | input | LINE_W | Number of the line that is starting |
| mode_wr | input | 1 | Write strobe for the CRT mode register |
| mode_data | input | 8 | Value written to the CRT mode register |
| disp_kill | input | 1 | High blocks all bus requests |
| alt_mode | input | 1 | High selects retrace-interrupt mode |
| bus_req | output | 1 | Bus request to the CPU |
| retrace_irq | output | 1 | One-clock vertical-retrace interrupt |
| frame_lines | output | LINE_W | Frame height for the alternate mode (200/204) |
| mode_flags | output | 2 | Inverted mode byte bits 3 and 2 |

## Verification
Every line number from 0 to 209 is swept under three setups: legacy with 200 active lines, legacy with 192 active lines, and alternate mode. Sampling bus_req just after line start, at clock HOLD and at clock HOLD+1 separates a wrong line boundary from a wrong hold length, and it also exposes a wrong polarity of the inverted bit. In the alternate sweep, the interrupt must appear only on the boundary line and only for one clock. Separate patterns cover three cases: kill raised before a line and in the middle of a request, a switch into alternate mode in the middle of a request, and a mode write in the same cycle as a line start, which shows the old setting still applies.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  // Decoded view of the CRT mode byte
  typedef struct packed {
    logic flag_hi;    // inverse of bit 3
    logic flag_lo;    // inverse of bit 2
    logic short_act;  // bit 1 set: fewer active lines
    logic alt_std;    // bit 0 set: standard alternate height
  } crt_cfg_t;

  localparam int MODE_W = 8;
endpackage

// File: rtl/sbt_mode_reg.sv
module sbt_mode_reg
  import sbt_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_VAL = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] data,
  output crt_cfg_t          cfg
);
  localparam int KEPT = 4;
  logic [KEPT-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bits_q <= RESET_VAL[KEPT-1:0];
    else if (wr) bits_q <= data[KEPT-1:0];
  end

  always_comb begin
    cfg.flag_hi   = ~bits_q[3];
    cfg.flag_lo   = ~bits_q[2];
    cfg.short_act = bits_q[1];
    cfg.alt_std   = bits_q[0];
  end
endmodule

// File: rtl/sbt_req_gen.sv
module sbt_req_gen #(
  parameter int LINE_W = 9,
  parameter int HOLD   = 368
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] active_cnt,
  input  logic              kill,
  input  logic              alt,
  output logic              req
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

  logic [CW-1:0] left_q;
  logic          begin_line;

  assign begin_line = line_start && (line_num < active_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      left_q <= '0;
    end else if (kill || alt) begin
      req    <= 1'b0;
      left_q <= '0;
    end else if (begin_line) begin
      req    <= 1'b1;
      left_q <= LOAD;
    end else if (req) begin
      if (left_q == '0) req <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/sbt_retrace_gen.sv
module sbt_retrace_gen #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] active_cnt,
  input  logic              alt,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= alt && line_start && (line_num == active_cnt);
  end
endmodule

// File: rtl/scanline_bus_timer.sv
module scanline_bus_timer
  import sbt_pkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int LINE_CLKS   = 456,
  parameter int HOLD_NUM    = 368,
  parameter int HOLD_DEN    = 456,
  parameter int ACT_LONG    = 200,
  parameter int ACT_SHORT   = 192,
  parameter int ALT_STD     = 200,
  parameter int ALT_TALL    = 204,
  parameter logic [7:0] MODE_RESET = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              mode_wr,
  input  logic [7:0]        mode_data,
  input  logic              disp_kill,
  input  logic              alt_mode,
  output logic              bus_req,
  output logic              retrace_irq,
  output logic [LINE_W-1:0] frame_lines,
  output logic [1:0]        mode_flags
);
  localparam int HOLD = LINE_CLKS * HOLD_NUM / HOLD_DEN;

  crt_cfg_t          cfg;
  logic [LINE_W-1:0] active_cnt;

  sbt_mode_reg #(.RESET_VAL(MODE_RESET)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .data(mode_data), .cfg(cfg)
  );

  assign active_cnt  = cfg.short_act ? LINE_W'(ACT_SHORT) : LINE_W'(ACT_LONG);
  assign frame_lines = cfg.alt_std   ? LINE_W'(ALT_STD)   : LINE_W'(ALT_TALL);
  assign mode_flags  = {cfg.flag_hi, cfg.flag_lo};

  sbt_req_gen #(.LINE_W(LINE_W), .HOLD(HOLD)) u_req (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .active_cnt(active_cnt), .kill(disp_kill), .alt(alt_mode), .req(bus_req)
  );

  sbt_retrace_gen #(.LINE_W(LINE_W)) u_vrt (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .active_cnt(active_cnt), .alt(alt_mode), .irq(retrace_irq)
  );
endmodule

// File: rtl/sbt_chk.sv
module sbt_chk (
  input logic clk,
  input logic rst_n,
  input logic line_start,
  input logic disp_kill,
  input logic alt_mode,
  input logic bus_req,
  input logic retrace_irq
);
  AST_KILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    disp_kill |=> !bus_req); // R5
  AST_ALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    alt_mode |=> !bus_req); // R6
  AST_REQ_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(line_start) && !$past(alt_mode) && !$past(disp_kill))); // R3
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retrace_irq) |-> ($past(line_start) && $past(alt_mode))); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (retrace_irq && !line_start) |=> !retrace_irq); // R7
  AST_IRQ_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_irq |-> !bus_req); // R6
endmodule

bind scanline_bus_timer sbt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .disp_kill(disp_kill),
  .alt_mode(alt_mode), .bus_req(bus_req), .retrace_irq(retrace_irq)
);

// File: tb/scanline_bus_timer_test.sv
`timescale 1ns/1ps
module scanline_bus_timer_test;
  localparam int LW    = 9;
  localparam int LCLK  = 57;
  localparam int HOLDV = 57 * 368 / 456; // 46

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [LW-1:0] line_num = '0;
  logic mode_wr = 1'b0;
  logic [7:0] mode_data = 8'h00;
  logic disp_kill = 1'b0;
  logic alt_mode = 1'b0;
  logic bus_req, retrace_irq;
  logic [LW-1:0] frame_lines;
  logic [1:0] mode_flags;

  int errors = 0;
  int checks = 0;
  logic [7:0] cur_mode = 8'h0E;

  always #2.5 clk = ~clk;

  scanline_bus_timer #(.LINE_W(LW), .LINE_CLKS(LCLK)) uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .mode_wr(mode_wr), .mode_data(mode_data), .disp_kill(disp_kill),
    .alt_mode(alt_mode), .bus_req(bus_req), .retrace_irq(retrace_irq),
    .frame_lines(frame_lines), .mode_flags(mode_flags)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int act_count(input logic [7:0] m);
    return m[1] ? 192 : 200;
  endfunction

  task automatic write_mode(input logic [7:0] v);
    @(negedge clk);
    mode_wr = 1'b1; mode_data = v;
    @(negedge clk);
    mode_wr = 1'b0;
    cur_mode = v;
  endtask

  // Runs one line and samples after clock 1, clock 2, clock HOLD and clock HOLD+1
  task automatic run_line(input int n);
    int ac;
    bit er, ei;
    ac = act_count(cur_mode);
    er = !alt_mode && !disp_kill && (n < ac);
    ei = alt_mode && (n == ac);
    @(negedge clk);
    line_start = 1'b1; line_num = LW'(n);
    @(negedge clk);
    line_start = 1'b0;
    check(er ? "R3" : "R4", int'(bus_req), int'(er));
    check("R7", int'(retrace_irq), int'(ei));
    @(negedge clk);
    check("R7", int'(retrace_irq), 0);
    repeat (HOLDV - 2) @(negedge clk);
    check("R4", int'(bus_req), int'(er));
    @(negedge clk);
    check("R4", int'(bus_req), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(bus_req), 0);
    check("R1", int'(retrace_irq), 0);
    check("R1", int'(frame_lines), 204);
    check("R1", int'(mode_flags), 0);
    run_line(191);   // R1: active count 192 after reset
    run_line(192);

    // R2/R3/R4 legacy sweep with 200 active lines
    write_mode(8'h01);
    check("R8", int'(frame_lines), 200);
    check("R9", int'(mode_flags), 3);
    for (int n = 0; n < 210; n++) run_line(n);
    // R2 sweep with 192 active lines
    write_mode(8'h06);
    check("R8", int'(frame_lines), 204);
    check("R9", int'(mode_flags), 2);
    check("R9", int'(uut.mode_flags), 2);
    for (int n = 0; n < 210; n++) run_line(n);
    write_mode(8'h0A);
    check("R9", int'(mode_flags), 1);

    // R7 alternate sweep (active count 192 with mode 0A)
    alt_mode = 1'b1;
    for (int n = 0; n < 210; n++) run_line(n);
    write_mode(8'h00);
    run_line(200);   // R7 boundary follows R2 count
    run_line(192);
    alt_mode = 1'b0;

    // R5 kill before a line and mid-request
    disp_kill = 1'b1;
    run_line(3);
    disp_kill = 1'b0;
    @(negedge clk);
    line_start = 1'b1; line_num = 9'd5;
    @(negedge clk);
    line_start = 1'b0;
    check("R5", int'(bus_req), 1);
    repeat (10) @(negedge clk);
    disp_kill = 1'b1;
    @(negedge clk);
    check("R5", int'(bus_req), 0);
    disp_kill = 1'b0;
    repeat (HOLDV) @(negedge clk);

    // R6 switch to alternate mode mid-request
    line_start = 1'b1; line_num = 9'd7;
    @(negedge clk);
    line_start = 1'b0;
    check("R6", int'(bus_req), 1);
    repeat (5) @(negedge clk);
    alt_mode = 1'b1;
    @(negedge clk);
    check("R6", int'(bus_req), 0);
    alt_mode = 1'b0;
    repeat (HOLDV) @(negedge clk);

    // R10 write in the same cycle as a line start uses the old count (200)
    line_start = 1'b1; line_num = 9'd195;
    mode_wr = 1'b1; mode_data = 8'h02;
    @(negedge clk);
    line_start = 1'b0; mode_wr = 1'b0;
    cur_mode = 8'h02;
    check("R10", int'(bus_req), 1);
    repeat (HOLDV + 2) @(negedge clk);
    run_line(195);   // R10 new count 192 now applies

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule